// File: doc/BRIEF.md
# Mailbox Channel Router and Collector

This block connects a pair of mailbox queues to a bank of numbered service channels. On the outbound side, a host write that lands in the send window carries its destination inside the word itself: the four least significant bits name the channel. The block captures the write for one cycle. In the next cycle it either hands the whole word to that channel or, if the channel reports busy, diverts the word into the outbound holding queue. It drops the word if that queue is full or if the channel number does not exist.

On the inbound side, the block collects responses. In every cycle where the inbound queue has room and at least one channel raises its available flag, it serves the lowest-numbered such channel. It pulses that channel's acknowledge and pushes the channel's response word into the inbound queue, unless the word is the reserved invalid value. Because the choice is made again each cycle, the scan always restarts from channel 0. Collection stops when the queue fills or when no channel has data. The queues themselves sit outside the block and are reached through push and full ports, so the owning queue can take a host pop in the same cycle as a push from the collector.

Top module: `mbx_route_collect`

## Requirements
- R1: A write is a send request only at byte offsets 0xA0, 0xA4, 0xA8 and 0xAC. A write to any other offset, including 0x9C, 0xA2 and 0xB0, produces no channel strobe and no outbound push.
- R2: A send request is acted on in the clock cycle that follows the cycle in which `wr_en` is sampled. Requests on consecutive cycles are acted on in consecutive cycles, in order.
- R3: The target channel is bits [3:0] of the written word. If that channel's busy flag is low, `ch_wstb` has exactly the bit of that channel set, and `ch_wdata` carries the whole 32-bit word.
- R4: If the target channel's busy flag is high, the whole word appears on `obq_data` with `obq_push` high, and no channel strobe is raised.
- R5: While `obq_full` is high, a send request is discarded: no push and no strobe, whether the channel is busy or not.
- R6: A send request whose bits [3:0] are not below NCH (9 to 15 with the default) is discarded.
- R7: When `ibq_full` is low and any `ch_avail` bit is set, `ch_ack` is one-hot on the lowest-numbered available channel. Otherwise `ch_ack` is zero.
- R8: The response word of the acknowledged channel is pushed into the inbound queue (`ibq_push`, `ibq_data`) unless it equals INVALID_WORD (default all ones). An invalid word is still acknowledged and takes one cycle, but it is not pushed.
- R9: While `ibq_full` is high, no channel is acknowledged and nothing is pushed, so pending available flags stay pending until room appears.
- R10: While reset is asserted no send request is captured. After release, no strobe or outbound push appears until a send request is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | AW (8) | Host write byte offset |
| wr_data | input | DW (32) | Host write data; bits [3:0] select the channel |
| obq_full | input | 1 | Outbound queue cannot accept a word |
| obq_push | output | 1 | Push into the outbound queue |
| obq_data | output | DW | Word pushed into the outbound queue |
| ch_busy | input | NCH (9) | Per-channel busy flag |
| ch_wstb | output | NCH | Per-channel delivery strobe |
| ch_wdata | output | DW | Word delivered to the strobed channel |
| ch_avail | input | NCH | Per-channel response-available flag |
| ch_resp | input | NCH*DW | Response words, channel i at bits [i*DW +: DW] |
| ch_ack | output | NCH | Per-channel fetch acknowledge |
| ibq_full | input | 1 | Inbound queue cannot accept a word |
| ibq_push | output | 1 | Push into the inbound queue |
| ibq_data | output | DW | Word pushed into the inbound queue |

## Verification
The bench uses the default nine channels. This leaves channel numbers 9 through 15 of the four-bit field reachable as out-of-range targets, while channel 8 exercises the top legal index. The bench's model of the inbound queue has a depth of three, so a single burst of four available channels can fill it. That brings the full-stop, the later resumption, and the overlap of pops with collector pushes within a few cycles. A scoreboard holds the expected outbound and inbound words with the cycle each should appear in, so ordering and latency are checked together with the data.

// File: rtl/mbx_route_collect.sv
module mbx_route_collect #(
  parameter int NCH = 9,
  parameter int DW = 32,
  parameter int AW = 8,
  parameter logic [DW-1:0] INVALID_WORD = '1,
  parameter logic [AW-1:0] SEND_BASE = 8'hA0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              obq_full,
  output logic              obq_push,
  output logic [DW-1:0]     obq_data,
  input  logic [NCH-1:0]    ch_busy,
  output logic [NCH-1:0]    ch_wstb,
  output logic [DW-1:0]     ch_wdata,
  input  logic [NCH-1:0]    ch_avail,
  input  logic [NCH*DW-1:0] ch_resp,
  output logic [NCH-1:0]    ch_ack,
  input  logic              ibq_full,
  output logic              ibq_push,
  output logic [DW-1:0]     ibq_data
);
  localparam int CHW = 4;
  localparam logic [AW-1:0] SLOT_MASK = AW'(12);

  logic          req_v;
  logic [DW-1:0] req_word;
  logic [CHW-1:0] req_ch;
  logic [15:0]   busy_ext;
  logic          ch_ok, busy_sel, go, deliver;
  logic          is_send;

  assign is_send = wr_en && ((wr_addr & ~SLOT_MASK) == SEND_BASE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_v    <= 1'b0;
      req_word <= '0;
    end else begin
      req_v <= is_send;
      if (is_send) req_word <= wr_data;
    end
  end

  assign req_ch   = req_word[CHW-1:0];
  assign busy_ext = 16'(ch_busy);
  assign busy_sel = busy_ext[req_ch];
  assign ch_ok    = 32'(req_ch) < NCH;
  assign go       = req_v && !obq_full && ch_ok;
  assign deliver  = go && !busy_sel;

  assign obq_push = go && busy_sel;
  assign obq_data = req_word;
  assign ch_wdata = req_word;

  for (genvar i = 0; i < NCH; i++) begin : g_wstb
    assign ch_wstb[i] = deliver && (req_ch == CHW'(i));
  end

  logic [NCH-1:0] pick;
  logic [DW-1:0]  sel_word;
  logic           collect;

  assign pick    = ch_avail & (~ch_avail + NCH'(1));
  assign collect = !ibq_full && (|ch_avail);
  assign ch_ack  = collect ? pick : '0;

  always_comb begin
    sel_word = '0;
    for (int i = 0; i < NCH; i++)
      if (pick[i]) sel_word = sel_word | ch_resp[i*DW +: DW];
  end

  assign ibq_data = sel_word;
  assign ibq_push = collect && (sel_word != INVALID_WORD);
endmodule

// File: rtl/mbx_route_collect_chk.sv
module mbx_route_collect_chk #(
  parameter int NCH = 9,
  parameter int DW = 32,
  parameter logic [DW-1:0] INVALID_WORD = '1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wr_en,
  input logic [DW-1:0]  wr_data,
  input logic           obq_full,
  input logic           obq_push,
  input logic [DW-1:0]  obq_data,
  input logic [NCH-1:0] ch_wstb,
  input logic [DW-1:0]  ch_wdata,
  input logic [NCH-1:0] ch_avail,
  input logic [NCH-1:0] ch_ack,
  input logic           ibq_full,
  input logic           ibq_push,
  input logic [DW-1:0]  ibq_data
);
  assert_send_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (obq_push || (|ch_wstb)) |-> $past(wr_en));

  assert_deliver_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_wstb) |-> ($countones(ch_wstb) == 1 && ch_wdata == $past(wr_data)));

  assert_divert_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    obq_push |-> (ch_wstb == '0 && obq_data == $past(wr_data)));

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    obq_full |-> (!obq_push && ch_wstb == '0));

  assert_chan_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    obq_push |-> (32'(obq_data[3:0]) < NCH));

  assert_ack_lowest_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_ack) |-> ($countones(ch_ack) == 1 && (ch_avail & ch_ack) != '0
                   && (ch_avail & (ch_ack - NCH'(1))) == '0));

  assert_push_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ibq_push |-> ((|ch_ack) && ibq_data != INVALID_WORD));

  assert_hold_when_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ibq_full |-> (ch_ack == '0 && !ibq_push));
endmodule

bind mbx_route_collect mbx_route_collect_chk #(
  .NCH(NCH), .DW(DW), .INVALID_WORD(INVALID_WORD)
) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .obq_full(obq_full), .obq_push(obq_push), .obq_data(obq_data),
  .ch_wstb(ch_wstb), .ch_wdata(ch_wdata), .ch_avail(ch_avail),
  .ch_ack(ch_ack), .ibq_full(ibq_full), .ibq_push(ibq_push),
  .ibq_data(ibq_data)
);

// File: tb/mbx_route_collect_tb_top.sv
module mbx_route_collect_tb_top;
  localparam int NCH = 9;
  localparam int DW = 32;
  localparam int IBD = 3;
  localparam logic [DW-1:0] BADW = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic            wr_en = 1'b0;
  logic [7:0]      wr_addr = '0;
  logic [DW-1:0]   wr_data = '0;
  logic            obq_full = 1'b0;
  logic            obq_push;
  logic [DW-1:0]   obq_data;
  logic [NCH-1:0]  ch_busy = '0;
  logic [NCH-1:0]  ch_wstb;
  logic [DW-1:0]   ch_wdata;
  logic [NCH-1:0]  ch_avail = '0;
  logic [NCH*DW-1:0] ch_resp = '0;
  logic [NCH-1:0]  ch_ack;
  logic            ibq_full;
  logic            ibq_push;
  logic [DW-1:0]   ibq_data;

  mbx_route_collect dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .obq_full(obq_full), .obq_push(obq_push), .obq_data(obq_data),
    .ch_busy(ch_busy), .ch_wstb(ch_wstb), .ch_wdata(ch_wdata),
    .ch_avail(ch_avail), .ch_resp(ch_resp), .ch_ack(ch_ack),
    .ibq_full(ibq_full), .ibq_push(ibq_push), .ibq_data(ibq_data)
  );

  int cyc = 0;
  int ib_cnt = 0;
  logic [NCH-1:0] set_mask = '0;
  logic pop_req = 1'b0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    ch_avail <= (ch_avail & ~ch_ack) | set_mask;
    ib_cnt <= ib_cnt + (ibq_push ? 1 : 0) - ((pop_req && ib_cnt > 0) ? 1 : 0);
  end
  assign ibq_full = ib_cnt >= IBD;

  typedef struct {
    bit          strobe;
    int          ch;
    logic [DW-1:0] data;
    int          at;
  } ob_t;
  ob_t ob_exp[$];
  logic [DW-1:0] ib_exp[$];

  int checks = 0;
  int fails = 0;
  int ob_seen = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (obq_push || (|ch_wstb)) begin
        ob_seen++;
        if (ob_exp.size() == 0) begin
          chk(0, "R1", "unexpected outbound event", {ch_wstb, 32'(obq_push)}, 0);
        end else begin
          ob_t e;
          e = ob_exp.pop_front();
          if (e.strobe) begin
            chk(ch_wstb == (NCH'(1) << e.ch) && !obq_push, "R3", "strobe", 64'(ch_wstb), 64'(NCH'(1) << e.ch));
            chk(ch_wdata == e.data, "R3", "wdata", 64'(ch_wdata), 64'(e.data));
          end else begin
            chk(obq_push && ch_wstb == '0, "R4", "divert", 64'(ch_wstb), 0);
            chk(obq_data == e.data, "R4", "obq_data", 64'(obq_data), 64'(e.data));
          end
          chk(cyc == e.at, "R2", "cycle", 64'(cyc), 64'(e.at));
        end
      end
      if (ibq_push) begin
        if (ib_exp.size() == 0) begin
          chk(0, "R8", "unexpected inbound push", 64'(ibq_data), 0);
        end else begin
          logic [DW-1:0] x;
          x = ib_exp.pop_front();
          chk(ibq_data == x, "R8", "ibq_data order", 64'(ibq_data), 64'(x));
        end
      end
    end
  end

  function automatic bit decoded(input logic [7:0] a);
    return a == 8'hA0 || a == 8'hA4 || a == 8'hA8 || a == 8'hAC;
  endfunction

  task automatic send(input logic [7:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_addr = a;
    wr_data = d;
    if (decoded(a) && !obq_full && int'(d[3:0]) < NCH) begin
      ob_t e;
      e.strobe = !ch_busy[d[3:0]];
      e.ch = int'(d[3:0]);
      e.data = d;
      e.at = cyc + 1;
      ob_exp.push_back(e);
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    wr_en = 1'b0;
    set_mask = '0;
    repeat (n) @(negedge clk);
  endtask

  task automatic raise(input logic [NCH-1:0] m);
    int cnt;
    logic [NCH-1:0] av;
    @(negedge clk);
    set_mask = m;
    cnt = ib_cnt;
    av = ch_avail | m;
    for (int i = 0; i < NCH; i++) begin
      if (av[i] && cnt < IBD) begin
        if (ch_resp[i*DW +: DW] != BADW) begin
          ib_exp.push_back(ch_resp[i*DW +: DW]);
          cnt++;
        end
      end else if (av[i]) begin
        break;
      end
    end
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n0;
    for (int i = 0; i < NCH; i++) ch_resp[i*DW +: DW] = 32'h5A00_0000 + 32'(i * 32'h111);
    ch_resp[2*DW +: DW] = BADW;

    // R10: writes presented during reset are not captured
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 8'hA0; wr_data = 32'h0000_0003;
    repeat (3) @(negedge clk);
    #2;
    chk(!obq_push && ch_wstb == '0, "R10", "outputs in reset", {ch_wstb, 32'(obq_push)}, 0);
    @(negedge clk);
    wr_en = 1'b0;
    rst_n = 1'b1;
    n0 = ob_seen;
    repeat (3) @(negedge clk);
    chk(ob_seen == n0, "R10", "no event after release", 64'(ob_seen), 64'(n0));

    // R3 / R1: delivery through every slot address
    send(8'hA0, 32'h1234_5672);
    send(8'hA4, 32'hCAFE_0008);
    send(8'hA8, 32'h0BAD_F000);
    send(8'hAC, 32'h7777_7774);
    idle(3);

    // R4: busy channel diverts to the outbound queue
    ch_busy = 9'b0_0010_0000;
    send(8'hA0, 32'hDEAD_BE05);
    send(8'hA4, 32'hFEED_0006);
    idle(3);

    // R5: full outbound queue discards, busy or not
    obq_full = 1'b1;
    n0 = ob_seen;
    send(8'hA0, 32'h1111_1115);
    send(8'hA8, 32'h2222_2221);
    idle(3);
    chk(ob_seen == n0, "R5", "discard when full", 64'(ob_seen), 64'(n0));
    obq_full = 1'b0;
    ch_busy = '0;

    // R6: out-of-range channel numbers
    n0 = ob_seen;
    send(8'hA0, 32'h0000_0009);
    send(8'hAC, 32'hFFFF_FFFF);
    idle(3);
    chk(ob_seen == n0, "R6", "bad channel discard", 64'(ob_seen), 64'(n0));

    // R1: offsets outside the send window
    n0 = ob_seen;
    send(8'h9C, 32'h0000_0001);
    send(8'hA2, 32'h0000_0001);
    send(8'hB0, 32'h0000_0001);
    idle(3);
    chk(ob_seen == n0, "R1", "foreign offsets ignored", 64'(ob_seen), 64'(n0));

    // R7 / R8: lowest first, invalid word skipped, queue fills
    raise(9'b1_0010_0110);
    idle(10);
    chk(ib_exp.size() == 0, "R8", "inbound words left", 64'(ib_exp.size()), 0);
    chk(ch_avail == '0, "R7", "all available served", 64'(ch_avail), 0);
    chk(ib_cnt == IBD, "R8", "queue count", 64'(ib_cnt), 64'(IBD));

    // R9: full inbound queue holds pending channels
    raise(9'b0_0000_1001);
    idle(6);
    chk(ch_avail == 9'b0_0000_1001, "R9", "pending held", 64'(ch_avail), 64'(9'b0_0000_1001));
    chk(ch_ack == '0 && !ibq_push, "R9", "no ack when full", 64'(ch_ack), 0);

    // R9 / R7: pops reopen room, collection resumes with overlap
    ib_exp.push_back(ch_resp[0 +: DW]);
    ib_exp.push_back(ch_resp[3*DW +: DW]);
    @(negedge clk);
    pop_req = 1'b1;
    repeat (8) @(negedge clk);
    pop_req = 1'b0;
    idle(2);
    chk(ib_exp.size() == 0, "R9", "resumed words left", 64'(ib_exp.size()), 0);
    chk(ch_avail == '0, "R7", "resumed channels served", 64'(ch_avail), 0);
    chk(ib_cnt == 0, "R9", "drained count", 64'(ib_cnt), 0);

    // R8: lone invalid response is acknowledged but not pushed
    raise(9'b0_0000_0100);
    idle(4);
    chk(ch_avail == '0, "R8", "invalid word acked", 64'(ch_avail), 0);
    chk(ib_cnt == 0, "R8", "invalid word not pushed", 64'(ib_cnt), 0);

    chk(ob_exp.size() == 0, "R2", "outbound words left", 64'(ob_exp.size()), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule